// File: doc/BRIEF.md
# Segment Limit Check and Linear Address Unit

This block sits in the address path of a load/store and fetch pipeline. It takes the cached state of one segment register and a memory access made through it. The segment state is the base, a 20-bit limit, a granularity flag, three type attribute bits, a default-size flag and a usable flag. The access is an offset, a kind (read, write or fetch) and a size of 1, 2 or 4 bytes. From these it forms the 32-bit linear address and decides whether the access breaks the segment's rules.

The range check follows the segment type. Code segments and expand-up data segments accept offsets from zero up to the scaled limit. Expand-down data segments accept offsets above the scaled limit, up to a ceiling chosen by the default-size flag. The type bits also gate the kind of access that is allowed. An access through a segment register that holds no usable segment always fails. A failure is reported as a stack-segment fault when the access went through the stack register, and as a general-protection fault otherwise.

By default the result is registered, so a response appears one clock after its request. A parameter can select a purely combinational variant instead.

Top module: `seg_xlate_unit`

## Requirements
- R1: The scaled limit equals the 20-bit limit when `seg_gran`=0, and equals (limit << 12) | 0xFFF when `seg_gran`=1.
- R2: For a code segment, or a data segment with `seg_attr[1]`=0, the access is in range only if offset + size − 1 is at most the scaled limit. A sum that passes 2^32 is out of range.
- R3: For a data segment with `seg_attr[1]`=1 (expand-down), the access is in range only if the offset is strictly greater than the scaled limit and offset + size − 1 is at most the ceiling. The ceiling is 0xFFFF when `seg_big`=0 and 0xFFFFFFFF when `seg_big`=1.
- R4: Every request gives `rsp_vld`=1 on the next clock, with `lin_addr` = (`seg_base` + `offset`) mod 2^32, whether or not the access faults.
- R5: When `seg_usable`=0, every access faults, whatever the other inputs are.
- R6: `seg_attr[2]`=1 marks a code segment; `seg_attr[0]` means readable on a code segment and writable on a data segment. Writes to code segments fault, and so do writes to data segments with `seg_attr[0]`=0. Reads from code segments with `seg_attr[0]`=0 fault, and so do fetches from data segments. Reads from data segments and fetches from code segments are always permitted.
- R7: A faulting access with `seg_is_stack`=1 raises only `flt_ss`, and one with `seg_is_stack`=0 raises only `flt_gp`. The two are never high together, and both stay low for an access that does not fault.
- R8: `acc_size` encodes the byte count as 00 = 1, 01 = 2, 10 = 4. The code 11 also means 4 bytes. `acc_kind` encodes 00 = read, 01 = write, 10 = fetch.
- R9: After reset, and in any cycle that follows a clock with `req_vld`=0, `rsp_vld`, `flt_gp` and `flt_ss` are 0 and `lin_addr` holds its previous value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Access request this cycle |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | Limit counts 4-KByte units when 1 |
| seg_attr | input | 3 | {code, expand-down/conforming, readable/writable} |
| seg_big | input | 1 | Default-size flag; picks the expand-down ceiling |
| seg_usable | input | 1 | 0 when the register holds a null selector |
| seg_is_stack | input | 1 | Access made through the stack register |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch |
| acc_size | input | 2 | 00 one byte, 01 two, 10/11 four |
| offset | input | 32 | Offset within the segment |
| rsp_vld | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| flt_gp | output | 1 | General-protection fault |
| flt_ss | output | 1 | Stack-segment fault |

## Verification
The pipeline has a single stage, so a wrong scaled limit, a bad range comparison or a wrong permission decode shows up as a wrong fault flag on the very next clock after the request. The bench sweeps offsets placed at, just below and just above the scaled limit, at the 16-bit ceiling and at the top of the address space. It does this for every type code, access kind and size, so an off-by-one or a lost carry in the end-address sum breaks a boundary case within the first few hundred responses. A mixed-up stack flag or a wrong base adder is caught on the same clock, through the fault class or through `lin_addr`.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   // byte count minus one from the size code (11 means four bytes)
   function automatic logic [1:0] size_to_last(input logic [1:0] code);
      case (code)
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/seg_limit_scale.sv
module seg_limit_scale #(
   parameter int AW         = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12
) (
   input  logic [LIM_W-1:0] limit,
   input  logic             gran,
   output logic [AW-1:0]    eff_lim
);
   localparam int SCALED_W = LIM_W + GRAN_SHIFT;
   localparam int PAD_W    = AW - SCALED_W;

   logic [SCALED_W-1:0] byte_lim;
   logic [SCALED_W-1:0] page_lim;

   // R1: byte granular limit sits in the low bits, page granular is filled with ones
   assign byte_lim = {{GRAN_SHIFT{1'b0}}, limit};
   assign page_lim = {limit, {GRAN_SHIFT{1'b1}}};

   generate
      if (PAD_W > 0) begin : g_pad
         assign eff_lim = {{PAD_W{1'b0}}, (gran ? page_lim : byte_lim)};
      end else begin : g_nopad
         assign eff_lim = gran ? page_lim : byte_lim;
      end
   endgenerate
endmodule

// File: rtl/seg_range_chk.sv
module seg_range_chk #(
   parameter int AW      = 32,
   parameter int SMALL_W = 16
) (
   input  logic [AW-1:0] offset,
   input  logic [1:0]    last_ofs,
   input  logic [AW-1:0] eff_lim,
   input  logic          expand_down,
   input  logic          big,
   output logic          in_range
);
   localparam logic [AW-1:0] SMALL_TOP = AW'({SMALL_W{1'b1}});

   logic [AW:0]   last_byte;
   logic [AW-1:0] ceiling;
   logic          up_ok;
   logic          dn_ok;

   // extra bit keeps the carry so a wrap past the top is seen
   assign last_byte = {1'b0, offset} + (AW+1)'(last_ofs);
   assign ceiling   = big ? '1 : SMALL_TOP;

   // R2: expand-up window [0, eff_lim], no wrap allowed
   assign up_ok = !last_byte[AW] && (last_byte[AW-1:0] <= eff_lim);
   // R3: expand-down window (eff_lim, ceiling]
   assign dn_ok = (offset > eff_lim) && (last_byte <= {1'b0, ceiling});

   assign in_range = expand_down ? dn_ok : up_ok;
endmodule

// File: rtl/seg_perm_chk.sv
module seg_perm_chk
   import seg_xlate_pkg::*;
(
   input  logic [2:0] attr,
   input  logic [1:0] kind,
   output logic       perm_ok
);
   logic is_code;
   logic rw_bit;

   assign is_code = attr[2];
   assign rw_bit  = attr[0];

   // R6: kind versus type permission matrix
   always_comb begin
      case (kind)
         ACC_WRITE: perm_ok = !is_code && rw_bit;
         ACC_READ:  perm_ok = !is_code || rw_bit;
         ACC_FETCH: perm_ok = is_code;
         default:   perm_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int SMALL_W    = 16,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [AW-1:0]    seg_base,
   input  logic [LIM_W-1:0] seg_limit,
   input  logic             seg_gran,
   input  logic [2:0]       seg_attr,
   input  logic             seg_big,
   input  logic             seg_usable,
   input  logic             seg_is_stack,
   input  logic [1:0]       acc_kind,
   input  logic [1:0]       acc_size,
   input  logic [AW-1:0]    offset,
   output logic             rsp_vld,
   output logic [AW-1:0]    lin_addr,
   output logic             flt_gp,
   output logic             flt_ss
);
   initial begin
      if (LIM_W + GRAN_SHIFT > AW)
         $fatal(1, "seg_xlate_unit: scaled limit wider than address");
      if (SMALL_W > AW)
         $fatal(1, "seg_xlate_unit: small ceiling wider than address");
   end

   logic [AW-1:0] eff_lim;
   logic          in_range;
   logic          perm_ok;
   logic          expand_down;
   logic          viol;
   logic          gp_c;
   logic          ss_c;
   logic [AW-1:0] lin_c;

   seg_limit_scale #(.AW(AW), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT)) u_scale (
      .limit   (seg_limit),
      .gran    (seg_gran),
      .eff_lim (eff_lim)
   );

   assign expand_down = !seg_attr[2] && seg_attr[1];

   seg_range_chk #(.AW(AW), .SMALL_W(SMALL_W)) u_range (
      .offset      (offset),
      .last_ofs    (size_to_last(acc_size)),
      .eff_lim     (eff_lim),
      .expand_down (expand_down),
      .big         (seg_big),
      .in_range    (in_range)
   );

   seg_perm_chk u_perm (
      .attr    (seg_attr),
      .kind    (acc_kind),
      .perm_ok (perm_ok)
   );

   // R5, R7: null segment overrides everything; class follows the register used
   assign viol  = !seg_usable || !perm_ok || !in_range;
   assign gp_c  = viol && !seg_is_stack;
   assign ss_c  = viol && seg_is_stack;
   assign lin_c = seg_base + offset;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rsp_vld  <= 1'b0;
               flt_gp   <= 1'b0;
               flt_ss   <= 1'b0;
               lin_addr <= '0;
            end else begin
               rsp_vld <= req_vld;
               flt_gp  <= req_vld && gp_c;
               flt_ss  <= req_vld && ss_c;
               if (req_vld) lin_addr <= lin_c;
            end
         end

         // R7
         fault_class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({flt_gp, flt_ss}));

         // R7
         stack_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld && !seg_is_stack |=> !flt_ss);

         // R5
         null_seg_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld && !seg_usable |=> rsp_vld && (flt_gp || flt_ss));

         // R6
         code_write_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld && seg_attr[2] && (acc_kind == ACC_WRITE) |=> flt_gp || flt_ss);

         // R9
         idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_vld |=> !rsp_vld && !flt_gp && !flt_ss && $stable(lin_addr));

         // R4
         resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_vld |=> rsp_vld);
      end else begin : g_comb
         assign rsp_vld  = req_vld;
         assign flt_gp   = req_vld && gp_c;
         assign flt_ss   = req_vld && ss_c;
         assign lin_addr = lin_c;
      end
   endgenerate
endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [31:0] seg_base = '0;
   logic [19:0] seg_limit = '0;
   logic        seg_gran = 1'b0;
   logic [2:0]  seg_attr = '0;
   logic        seg_big = 1'b0;
   logic        seg_usable = 1'b1;
   logic        seg_is_stack = 1'b0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  acc_size = '0;
   logic [31:0] offset = '0;
   logic        rsp_vld;
   logic [31:0] lin_addr;
   logic        flt_gp;
   logic        flt_ss;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_xlate_unit u_seg_xlate_unit (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .seg_base(seg_base),
      .seg_limit(seg_limit), .seg_gran(seg_gran), .seg_attr(seg_attr),
      .seg_big(seg_big), .seg_usable(seg_usable), .seg_is_stack(seg_is_stack),
      .acc_kind(acc_kind), .acc_size(acc_size), .offset(offset),
      .rsp_vld(rsp_vld), .lin_addr(lin_addr), .flt_gp(flt_gp), .flt_ss(flt_ss)
   );

   // expected fault from the requirements, in 64-bit arithmetic
   function automatic bit exp_fault(output string tag);
      logic [63:0] eff, last, ceil_v;
      bit code, perm, ed, rng;
      eff    = seg_gran ? ((64'(seg_limit) << 12) | 64'hFFF) : 64'(seg_limit);
      last   = 64'(offset) + ((acc_size == 2'b00) ? 64'd0 : (acc_size == 2'b01) ? 64'd1 : 64'd3);
      ceil_v = seg_big ? 64'hFFFF_FFFF : 64'hFFFF;
      code   = seg_attr[2];
      case (acc_kind)
         2'd1:    perm = !code && seg_attr[0];
         2'd0:    perm = !code || seg_attr[0];
         default: perm = code;
      endcase
      ed  = !code && seg_attr[1];
      rng = ed ? ((64'(offset) > eff) && (last <= ceil_v)) : (last <= eff);
      if (!seg_usable)   tag = "R5";
      else if (!perm)    tag = "R6";
      else if (ed)       tag = "R3";
      else               tag = "R2";
      if (acc_size == 2'b11) tag = {tag, " R8"};
      return !seg_usable || !perm || !rng;
   endfunction

   task automatic chk(input string tag, input logic [33:0] got, input logic [33:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // inputs already set; one clock through, then check at the negedge
   task automatic issue_and_check(input string force_tag);
      string tag;
      bit f;
      logic [31:0] ea;
      f  = exp_fault(tag);
      if (force_tag != "") tag = force_tag;
      ea = seg_base + offset;
      req_vld = 1'b1;
      @(negedge clk);
      chk({tag, " R7"}, {32'd0, flt_gp, flt_ss},
          {32'd0, f && !seg_is_stack, f && seg_is_stack});
      chk("R4", {1'b0, rsp_vld, lin_addr}, {1'b0, 1'b1, ea});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lims [3];
      logic [31:0] eff;
      logic [31:0] offs [9];
      lims[0] = 32'h00000; lims[1] = 32'h0FFF0; lims[2] = 32'hFFFFF;

      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", {rsp_vld, flt_gp, flt_ss, lin_addr[30:0]}, 34'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", {rsp_vld, flt_gp, flt_ss, lin_addr[30:0]}, 34'd0);

      // R1: scaling boundaries
      seg_attr = 3'b001; acc_kind = 2'd0; acc_size = 2'b00; seg_base = 32'h100;
      seg_limit = 20'h1; seg_gran = 1'b1; offset = 32'h1FFF; issue_and_check("R1");
      offset = 32'h2000; issue_and_check("R1");
      seg_gran = 1'b0; offset = 32'h1; issue_and_check("R1");
      offset = 32'h2; issue_and_check("R1");

      // R9: idle cycle after a request keeps outputs quiet and address held
      seg_usable = 1'b0; offset = 32'h55; issue_and_check("R5");
      req_vld = 1'b0; offset = 32'h9999;
      @(negedge clk);
      chk("R9", {rsp_vld, flt_gp, flt_ss, lin_addr}, {3'b000, 32'h155});
      seg_usable = 1'b1;

      // R2 R3 R6 R7 R8 R4: sweep over type, kind, size, granularity, ceiling
      for (int li = 0; li < 3; li++)
         for (int g = 0; g < 2; g++)
            for (int b = 0; b < 2; b++)
               for (int t = 0; t < 8; t++)
                  for (int k = 0; k < 3; k++)
                     for (int s = 0; s < 4; s++)
                        for (int oi = 0; oi < 9; oi++) begin
                           seg_limit = lims[li][19:0];
                           seg_gran = g[0];
                           seg_big = b[0];
                           seg_attr = t[2:0];
                           acc_kind = k[1:0];
                           acc_size = s[1:0];
                           eff = g ? {lims[li][19:0], 12'hFFF} : lims[li];
                           offs[0] = 32'd0;        offs[1] = eff - 32'd3;
                           offs[2] = eff - 32'd1;  offs[3] = eff;
                           offs[4] = eff + 32'd1;  offs[5] = 32'hFFFC;
                           offs[6] = 32'hFFFF;     offs[7] = 32'hFFFF_FFFD;
                           offs[8] = 32'hFFFF_FFFF;
                           offset = offs[oi];
                           seg_is_stack = ((t + oi + s) % 2) == 1;
                           seg_base = 32'hF000_0000 + 32'(li * 32'h0123_4567) + 32'(oi << 4);
                           issue_and_check("");
                        end

      // R5: unusable segment faults for every kind and type
      seg_usable = 1'b0; seg_limit = 20'hFFFFF; seg_gran = 1'b1;
      for (int t = 0; t < 8; t++)
         for (int k = 0; k < 3; k++) begin
            seg_attr = t[2:0]; acc_kind = k[1:0]; offset = 32'h10;
            seg_is_stack = k[0];
            issue_and_check("");
         end
      req_vld = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule